// File: doc/BRIEF.md
# Shared-Line Interrupt Router

This block sits between eight level-sensitive shared interrupt requests (lettered A to H, numbered 0 to 7 here) and a bank of 24 interrupt lines. Lines 0 to 15 feed a legacy interrupt controller and lines 16 to 23 feed an advanced controller. Both views are driven at the same time. In the legacy view any number of requests may share one line and each request can be cut off on its own. In the advanced view request n always owns line 16+n.

A byte-wide configuration port holds one route byte per request and a power-management control byte. The control byte places a system control interrupt (SCI) level on one of five lines. Moving that selection while the SCI is active drops it from the old line and raises it on the new one. A query port reports where a chosen request currently lands, and a one-cycle pulse announces every write to a route byte so that consumers of the routing can refresh their view.

All 24 line levels and the query answer are registered. Each reflects the request, SCI and configuration values present one clock earlier.

Top module: `pirq_router`

## Requirements
- R1: A synchronous reset sets every route byte to 0x80 (disconnected), selects line 9 for the SCI, and clears `irq_out`, `route_chg`, `qry_ok` and `qry_line`.
- R2: Legacy line g (0 to 15) is the OR of every request whose route byte has bit 7 clear, whose bits 4:0 equal g, and whose input is high.
- R3: A request whose route byte has bit 7 set drives no legacy line, whatever bits 4:0 hold. A request routed to a value of 16 or more also drives no legacy line.
- R4: Line 16+n follows request n alone, whatever its route byte holds.
- R5: Writing the control byte (address 8) takes its bits 2:0 as the SCI select: 0 gives line 9, 1 gives 10, 2 gives 11, 4 gives 20, 5 gives 21. The values 3, 6 and 7 leave the current SCI line as it was.
- R6: The SCI level is ORed onto its selected line (legacy or advanced). Any nonzero value of `sci_lvl` counts as asserted, and holding a level drives the line the same way as the first cycle did.
- R7: When the SCI is asserted and its line is reselected, the old line falls and the new line rises on the same output update.
- R8: The query for request `qry_sel` returns, one cycle later, `qry_ok`=1 with line 16+n when bit 7 is set, `qry_ok`=1 with line = bits 4:0 when bit 7 is clear and bits 4:0 are below 16, and `qry_ok`=0 with line 0 otherwise.
- R9: `route_chg` pulses high for exactly the cycle after a write to a route byte (addresses 0 to 7). A write to address 8 raises no pulse.
- R10: Every `irq_out` bit reflects the inputs and configuration sampled at the previous clock edge. A configuration write changes the lines one edge after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Byte address: 0-7 route bytes, 8 control byte |
| cfg_wdata | input | 8 | Write data |
| pirq_lvl | input | 8 | Shared request levels, bit n is request n |
| sci_lvl | input | 4 | SCI level, any nonzero value is asserted |
| qry_sel | input | 3 | Request number to look up |
| irq_out | output | 24 | Registered interrupt line levels |
| route_chg | output | 1 | Route-changed pulse |
| qry_ok | output | 1 | Query result: request reaches a line |
| qry_line | output | 5 | Query result: line number |

## Verification
A corrupted route byte shows up one edge after the request it governs goes high. The request lands on a wrong legacy line, or a line that should stay quiet rises. A check of all 24 bits after each stimulus catches it on the first sample. A stale or wrong SCI line register shows as a missing or misplaced single bit as soon as the SCI is asserted, or as two bits at once right after a reselection. The query port exposes the stored route state directly, one cycle after selection, so decode faults there are visible without any request activity.

// File: rtl/pirq_rt_pkg.sv
package pirq_rt_pkg;

  localparam int BYTE_W   = 8;
  localparam int FIELD_W  = 5;
  localparam int DIS_BIT  = 7;
  localparam int SEL_W    = 3;
  localparam logic [BYTE_W-1:0] ROUTE_RST = 8'h80;

  typedef struct packed {
    logic               ok;
    logic [FIELD_W-1:0] line;
  } sci_pick_t;

  function automatic sci_pick_t sci_decode(input logic [SEL_W-1:0] sel);
    sci_pick_t r;
    r.ok   = 1'b1;
    r.line = 5'd9;
    case (sel)
      3'd0:    r.line = 5'd9;
      3'd1:    r.line = 5'd10;
      3'd2:    r.line = 5'd11;
      3'd4:    r.line = 5'd20;
      3'd5:    r.line = 5'd21;
      default: r.ok   = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pirq_rt_cfg.sv
module pirq_rt_cfg
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ = 8,
  parameter int LINE_W = 5,
  parameter int CFG_AW = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CFG_AW-1:0]              addr,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [N_PIRQ-1:0][BYTE_W-1:0]  route_q,
  output logic [LINE_W-1:0]              sci_line_q,
  output logic                           route_chg
);

  localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(N_PIRQ);

  sci_pick_t pick;
  logic      hit_route;

  assign pick      = sci_decode(wdata[SEL_W-1:0]);
  assign hit_route = wr_en && (addr < CTRL_ADDR);

  for (genvar n = 0; n < N_PIRQ; n++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) begin
        route_q[n] <= ROUTE_RST;
      end else if (wr_en && addr == CFG_AW'(n)) begin
        route_q[n] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_line_q <= LINE_W'(9);
      route_chg  <= 1'b0;
    end else begin
      route_chg <= hit_route;
      if (wr_en && addr == CTRL_ADDR && pick.ok) begin
        sci_line_q <= LINE_W'(pick.line);
      end
    end
  end

endmodule

// File: rtl/pirq_rt_leg.sv
module pirq_rt_leg
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ = 8,
  parameter int N_LEG  = 16
) (
  input  logic [N_PIRQ-1:0]             pirq_lvl,
  input  logic [N_PIRQ-1:0][BYTE_W-1:0] route_q,
  output logic [N_LEG-1:0]              leg_lvl
);

  logic [N_PIRQ-1:0] live;

  for (genvar n = 0; n < N_PIRQ; n++) begin : g_live
    assign live[n] = pirq_lvl[n] && !route_q[n][DIS_BIT];
  end

  for (genvar g = 0; g < N_LEG; g++) begin : g_line
    always_comb begin
      leg_lvl[g] = 1'b0;
      for (int n = 0; n < N_PIRQ; n++) begin
        if (live[n] && route_q[n][FIELD_W-1:0] == FIELD_W'(g)) begin
          leg_lvl[g] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pirq_rt_qry.sv
module pirq_rt_qry
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ = 8,
  parameter int N_LEG  = 16,
  parameter int LINE_W = 5,
  parameter int SEL_QW = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_QW-1:0]             sel,
  input  logic [N_PIRQ-1:0][BYTE_W-1:0] route_q,
  output logic                          ok_q,
  output logic [LINE_W-1:0]             line_q
);

  logic [BYTE_W-1:0] rb;
  logic              ok_d;
  logic [LINE_W-1:0] line_d;

  assign rb = route_q[sel];

  always_comb begin
    if (rb[DIS_BIT]) begin
      ok_d   = 1'b1;
      line_d = LINE_W'(N_LEG) + LINE_W'(sel);
    end else if (32'(rb[FIELD_W-1:0]) < N_LEG) begin
      ok_d   = 1'b1;
      line_d = LINE_W'(rb[FIELD_W-1:0]);
    end else begin
      ok_d   = 1'b0;
      line_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q   <= 1'b0;
      line_q <= '0;
    end else begin
      ok_q   <= ok_d;
      line_q <= line_d;
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ = 8,
  parameter int N_LEG  = 16,
  parameter int SCI_W  = 4,
  parameter int LINES  = N_LEG + N_PIRQ,
  parameter int LINE_W = $clog2(LINES),
  parameter int CFG_AW = $clog2(N_PIRQ + 1),
  parameter int SEL_QW = $clog2(N_PIRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [N_PIRQ-1:0] pirq_lvl,
  input  logic [SCI_W-1:0]  sci_lvl,
  input  logic [SEL_QW-1:0] qry_sel,
  output logic [LINES-1:0]  irq_out,
  output logic              route_chg,
  output logic              qry_ok,
  output logic [LINE_W-1:0] qry_line
);

  logic [N_PIRQ-1:0][BYTE_W-1:0] route_q;
  logic [LINE_W-1:0]             sci_line_q;
  logic [N_LEG-1:0]              leg_lvl;
  logic [LINES-1:0]              line_d;
  logic                          sci_on;

  assign sci_on = |sci_lvl;

  pirq_rt_cfg #(
    .N_PIRQ(N_PIRQ), .LINE_W(LINE_W), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .route_q(route_q), .sci_line_q(sci_line_q),
    .route_chg(route_chg)
  );

  pirq_rt_leg #(
    .N_PIRQ(N_PIRQ), .N_LEG(N_LEG)
  ) u_leg (
    .pirq_lvl(pirq_lvl), .route_q(route_q), .leg_lvl(leg_lvl)
  );

  pirq_rt_qry #(
    .N_PIRQ(N_PIRQ), .N_LEG(N_LEG), .LINE_W(LINE_W), .SEL_QW(SEL_QW)
  ) u_qry (
    .clk(clk), .rst(rst), .sel(qry_sel), .route_q(route_q),
    .ok_q(qry_ok), .line_q(qry_line)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_mix
    logic base;
    if (g < N_LEG) begin : g_legacy
      assign base = leg_lvl[g];
    end else begin : g_adv
      assign base = pirq_lvl[g-N_LEG];
    end
    assign line_d[g] = base | (sci_on && sci_line_q == LINE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= '0;
    end else begin
      irq_out <= line_d;
    end
  end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_PIRQ = 8,
  parameter int N_LEG  = 16,
  parameter int SCI_W  = 4,
  parameter int LINES  = 24,
  parameter int LINE_W = 5,
  parameter int CFG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [N_PIRQ-1:0] pirq_lvl,
  input logic [SCI_W-1:0]  sci_lvl,
  input logic [LINES-1:0]  irq_out,
  input logic              route_chg,
  input logic              qry_ok,
  input logic [LINE_W-1:0] qry_line
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_ADV_FOLLOW: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(pirq_lvl) & ~irq_out[LINES-1 -: N_PIRQ]) == '0)); // R4

  AST_ADV_SCI_ONLY: assert property (@(posedge clk) disable iff (rst || !armed)
    ($countones(irq_out[LINES-1 -: N_PIRQ] & ~$past(pirq_lvl)) <= 1)); // R6

  AST_SCI_SINGLE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(pirq_lvl) == '0 && $past(sci_lvl) != '0) |-> $countones(irq_out) == 1); // R6

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(pirq_lvl) == '0 && $past(sci_lvl) == '0) |-> irq_out == '0); // R10

  AST_CHG_SOURCE: assert property (@(posedge clk) disable iff (rst || !armed)
    route_chg |-> $past(cfg_wr_en && (cfg_addr < CFG_AW'(N_PIRQ)))); // R9

  AST_QRY_RANGE: assert property (@(posedge clk) disable iff (rst || !armed)
    qry_ok |-> (32'(qry_line) < LINES)); // R8

endmodule

bind pirq_router pirq_router_chk #(
  .N_PIRQ(N_PIRQ), .N_LEG(N_LEG), .SCI_W(SCI_W), .LINES(LINES),
  .LINE_W(LINE_W), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl), .irq_out(irq_out),
  .route_chg(route_chg), .qry_ok(qry_ok), .qry_line(qry_line)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  pirq_lvl;
  logic [3:0]  sci_lvl;
  logic [2:0]  qry_sel;
  logic [23:0] irq_out;
  logic        route_chg;
  logic        qry_ok;
  logic [4:0]  qry_line;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_route [8];
  int         m_sci = 9;

  always #5 clk = ~clk;

  pirq_router u_pirq_router (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .qry_sel(qry_sel), .irq_out(irq_out), .route_chg(route_chg),
    .qry_ok(qry_ok), .qry_line(qry_line)
  );

  function automatic logic [23:0] model(input logic [7:0] p, input logic s);
    logic [23:0] e = '0;
    for (int n = 0; n < 8; n++) begin
      if (!m_route[n][7] && m_route[n][4:0] < 5'd16 && p[n]) e[m_route[n][4:0]] = 1'b1;
      if (p[n]) e[16+n] = 1'b1;
    end
    if (s) e[m_sci] = 1'b1;
    return e;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr_en = 1'b0;
    chk(32'(route_chg), 32'(a < 4'd8), "R9 route_chg after write");
    if (a < 4'd8) m_route[a] = d;
    else case (d[2:0])
      3'd0: m_sci = 9;  3'd1: m_sci = 10; 3'd2: m_sci = 11;
      3'd4: m_sci = 20; 3'd5: m_sci = 21; default: ;
    endcase
  endtask

  task automatic drive_lines(input logic [7:0] p, input logic [3:0] s, input string req);
    pirq_lvl = p; sci_lvl = s;
    tick();
    chk(32'(irq_out), 32'(model(p, s != 4'd0)), req);
  endtask

  task automatic query(input int n, input logic ok, input int line, input string req);
    qry_sel = 3'(n);
    tick();
    chk(32'(qry_ok), 32'(ok), req);
    chk(32'(qry_line), 32'(line), req);
  endtask

  task automatic t_reset;
    chk(32'(irq_out), 0, "R1 lines after reset");
    chk(32'(route_chg), 0, "R1 route_chg after reset");
    drive_lines(8'hFF, 4'd0, "R1 R3 disconnected default");
    chk(32'(irq_out), 32'h00FF0000, "R4 advanced view only");
    for (int n = 0; n < 8; n++) query(n, 1'b1, 16 + n, "R1 R8 default query");
    drive_lines(8'h00, 4'd0, "R10 release");
  endtask

  task automatic t_legacy_share;
    wr(4'd0, 8'h05); wr(4'd1, 8'h05); wr(4'd2, 8'h07);
    drive_lines(8'h01, 4'd0, "R2 A on line 5");
    chk(32'(irq_out[5]), 1, "R2 line 5 high");
    drive_lines(8'h02, 4'd0, "R2 B on line 5");
    drive_lines(8'h03, 4'd0, "R2 A|B on line 5");
    drive_lines(8'h04, 4'd0, "R2 C on line 7");
    chk(32'(irq_out), 32'h00040080, "R2 R4 C exact");
    drive_lines(8'h00, 4'd0, "R2 all low");
  endtask

  task automatic t_disable;
    wr(4'd0, 8'h85);
    drive_lines(8'h01, 4'd0, "R3 disabled A");
    chk(32'(irq_out[5]), 0, "R3 line 5 stays low");
    wr(4'd3, 8'h14);
    drive_lines(8'h08, 4'd0, "R3 field 20 no legacy");
    chk(32'(irq_out), 32'h00080000, "R3 R4 only advanced");
    drive_lines(8'h00, 4'd0, "R3 low");
  endtask

  task automatic t_latency;
    pirq_lvl = 8'h04;
    #1;
    chk(32'(irq_out), 0, "R10 no change before edge");
    tick();
    chk(32'(irq_out), 32'h00040080, "R10 after one edge");
    wr(4'd2, 8'h0C);
    chk(32'(irq_out), 32'h00040080, "R10 old route on write edge");
    tick();
    chk(32'(irq_out), 32'h00041000, "R10 new route one edge later");
    pirq_lvl = 8'h00; tick();
  endtask

  task automatic t_sci_select;
    drive_lines(8'h00, 4'd1, "R6 SCI default line 9");
    chk(32'(irq_out), 32'h00000200, "R6 line 9");
    drive_lines(8'h00, 4'd8, "R6 nonzero value asserted");
    drive_lines(8'h00, 4'd8, "R6 repeated level same");
    wr(4'd8, 8'h02); tick();
    chk(32'(irq_out), 32'h00000800, "R5 select 2 line 11");
    wr(4'd8, 8'h06); tick();
    chk(32'(irq_out), 32'h00000800, "R5 reserved keeps line 11");
    wr(4'd8, 8'h03); tick();
    chk(32'(irq_out), 32'h00000800, "R5 reserved 3 keeps line");
    wr(4'd8, 8'h04); tick();
    chk(32'(irq_out), 32'h00100000, "R5 select 4 line 20");
    drive_lines(8'h10, 4'd2, "R6 SCI ORed with request 4");
    chk(32'(irq_out), 32'h00100000, "R6 shared line 20");
    drive_lines(8'h00, 4'd0, "R6 SCI low");
  endtask

  task automatic t_sci_move;
    wr(4'd8, 8'h01);
    drive_lines(8'h00, 4'd3, "R7 on line 10");
    chk(32'(irq_out), 32'h00000400, "R7 before move");
    wr(4'd8, 8'h05);
    tick();
    chk(32'(irq_out), 32'h00200000, "R7 moved to 21 old low");
    drive_lines(8'h00, 4'd0, "R7 release");
  endtask

  task automatic t_query;
    wr(4'd5, 8'h0E); wr(4'd6, 8'h10); wr(4'd7, 8'h83);
    query(5, 1'b1, 14, "R8 enabled field 14");
    query(6, 1'b0, 0, "R8 field 16 reports disabled");
    query(7, 1'b1, 23, "R8 disable bit gives 16+n");
    query(3, 1'b0, 0, "R8 field 20 reports disabled");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pirq_lvl = '0; sci_lvl = '0; qry_sel = '0;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_legacy_share();
    t_disable();
    t_latency();
    t_sci_select();
    t_sci_move();
    t_query();
    summary();
  end

endmodule